// File: doc/BRIEF.md
# Window Framebuffer Fetch Address Generator

This block produces the read addresses a display window uses to pull a rectangle out of a larger framebuffer in memory. Software programs four values: the byte address of the first pixel of the rectangle, the byte address just past its last line, the number of bytes fetched on each line (the page width), and the number of bytes passed over between the end of one line and the start of the next (the skip). The pitch of the framebuffer is page width plus skip. At each frame start the block walks the rectangle line by line. It issues read bursts over a valid/ready handshake, and each request carries a word address and a length in 32-bit words.

Programmed values go to shadow registers. They reach the active set only at a frame start, so software may rewrite them at any time without disturbing the frame being fetched. A status output reports whether the active start address equals the shadow start address, which tells software that its update has taken effect. The burst length depends on the pixel format. Narrow buffers use short bursts. Both choices are made at frame start.

Top module: `win_fetch_addr_gen`

## Requirements
- R1: A `frame_start` pulse in any state copies the shadow values, format and buffer width into the active set and restarts the walk. The first request that follows carries the active start address. No request is valid in the cycle after `frame_start`.
- R2: The burst length in words comes from `fmt`. Code 0 (8-bit palette) gives 8. Codes 1 (16-bit), 2 (32-bit) and 3 (32-bit with alpha) give 16.
- R3: When `buf_width` is below `NARROW_PIX` (128 by default), the burst length is 4 words for every format.
- R4: Each line is fetched as consecutive full bursts from the line start. The final burst of the line is shortened to the words that remain of the page width (page width / 4 words), so that no request crosses the line end. `req_len` is always from 1 to 16.
- R5: After the last burst of a line, the next request starts at that line's start plus page width plus skip.
- R6: When a line start reaches or passes the end address, or the page width is below one word, the block raises `frame_done` for exactly one cycle. It then issues no request until the next `frame_start`. An end address equal to the start address gives `frame_done` with no request at all.
- R7: While `req_valid` is high and `req_ready` is low, the request stays valid with its address and length unchanged.
- R8: Shadow writes made during a frame do not change that frame's requests. The write select is 0 for start, 1 for end, 2 for page width and 3 for skip.
- R9: `shadow_match` is high exactly when the active start address equals the shadow start address. It drops after a start write with a new value and rises again once a `frame_start` has loaded that value.
- R10: After reset, all shadow and active values are zero, `req_valid` and `frame_done` are low, and `shadow_match` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Shadow register write strobe |
| wr_sel | input | 2 | Shadow field select: 0 start, 1 end, 2 page width, 3 skip |
| wr_data | input | ADDR_W | Value written to the selected shadow field |
| fmt | input | 2 | Pixel format code, sampled at frame start |
| buf_width | input | WIDTH_W | Buffer width in pixels, sampled at frame start |
| frame_start | input | 1 | Frame start pulse |
| req_ready | input | 1 | Memory side accepts the request |
| req_valid | output | 1 | Read request valid |
| req_addr | output | ADDR_W | Byte address of the request |
| req_len | output | 5 | Request length in 32-bit words |
| frame_done | output | 1 | One-cycle pulse when the frame fetch is complete |
| shadow_match | output | 1 | Active start address equals shadow start address |

## Verification
The bench keeps the default 32-bit addresses, 16-bit page counter and 128-pixel narrow threshold. It uses small page widths of 1, 9, 16 and 25 words, so that every rectangle needs only a handful of bursts. This makes a full sweep practical: every format code, buffer widths just below, at and above the threshold, two skip values and one to three lines, combined with three ready patterns. The sweep reaches single-word lines, truncated final bursts after both 4- and 8-word bursts, and exact multiples of 16 words. Separate cases cover an empty rectangle, a zero page width and a shadow write made in the middle of a frame.

// File: rtl/fwag_pkg.sv
package fwag_pkg;

   typedef enum logic [1:0] {
      FMT_PAL8  = 2'd0,
      FMT_HALF  = 2'd1,
      FMT_FULL  = 2'd2,
      FMT_FULLA = 2'd3
   } fmt_e;

   typedef enum logic [1:0] {
      WK_IDLE = 2'd0,
      WK_LOAD = 2'd1,
      WK_RUN  = 2'd2
   } walk_st_e;

   localparam int unsigned LEN_W       = 5;
   localparam int unsigned BURST_SHORT = 4;
   localparam int unsigned BURST_MID   = 8;
   localparam int unsigned BURST_LONG  = 16;
   localparam int unsigned NUM_FIELDS  = 4;

   localparam logic [1:0] SEL_START = 2'd0;
   localparam logic [1:0] SEL_END   = 2'd1;
   localparam logic [1:0] SEL_PAGE  = 2'd2;
   localparam logic [1:0] SEL_SKIP  = 2'd3;

   function automatic logic [LEN_W-1:0] fmt_burst(input logic [1:0] code);
      logic [LEN_W-1:0] b;
      if (code == FMT_PAL8) b = LEN_W'(BURST_MID);
      else                  b = LEN_W'(BURST_LONG);
      return b;
   endfunction

endpackage

// File: rtl/fwag_shadow_regs.sv
module fwag_shadow_regs
   import fwag_pkg::*;
#(
   parameter int unsigned ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [ADDR_W-1:0] wr_data,
   input  logic              load,
   output logic [ADDR_W-1:0] sh_start,
   output logic [ADDR_W-1:0] act_start,
   output logic [ADDR_W-1:0] act_end,
   output logic [ADDR_W-1:0] act_page,
   output logic [ADDR_W-1:0] act_skip
);

   for (genvar gi = 0; gi < NUM_FIELDS; gi++) begin : g_fld
      logic [ADDR_W-1:0] sh_q;
      logic [ADDR_W-1:0] act_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            sh_q  <= '0;
            act_q <= '0;
         end else begin
            if (wr_en && (wr_sel == 2'(gi))) sh_q <= wr_data;
            if (load) act_q <= sh_q;
         end
      end
   end

   assign sh_start  = g_fld[SEL_START].sh_q;
   assign act_start = g_fld[SEL_START].act_q;
   assign act_end   = g_fld[SEL_END].act_q;
   assign act_page  = g_fld[SEL_PAGE].act_q;
   assign act_skip  = g_fld[SEL_SKIP].act_q;

endmodule

// File: rtl/fwag_burst_sel.sv
module fwag_burst_sel
   import fwag_pkg::*;
#(
   parameter int unsigned WIDTH_W    = 12,
   parameter int unsigned NARROW_PIX = 128
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [1:0]         fmt,
   input  logic [WIDTH_W-1:0] buf_width,
   output logic [LEN_W-1:0]   burst
);

   logic narrow;

   if (NARROW_PIX > 0) begin : g_narrow
      assign narrow = (32'(buf_width) < NARROW_PIX);
   end else begin : g_wide_only
      assign narrow = 1'b0 & (|buf_width);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         burst <= LEN_W'(BURST_SHORT);
      end else if (load) begin
         burst <= narrow ? LEN_W'(BURST_SHORT) : fmt_burst(fmt);
      end
   end

endmodule

// File: rtl/fwag_walker.sv
module fwag_walker
   import fwag_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned PAGE_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic [ADDR_W-1:0] act_start,
   input  logic [ADDR_W-1:0] act_end,
   input  logic [ADDR_W-1:0] act_page,
   input  logic [ADDR_W-1:0] act_skip,
   input  logic [LEN_W-1:0]  burst,
   input  logic              req_ready,
   output logic              req_valid,
   output logic [ADDR_W-1:0] req_addr,
   output logic [LEN_W-1:0]  req_len,
   output logic              frame_done
);

   localparam int unsigned CW = PAGE_W - 2;

   walk_st_e          st;
   logic [ADDR_W-1:0] line_base;
   logic [ADDR_W-1:0] cur;
   logic [CW-1:0]     left;
   logic [CW-1:0]     page_words;
   logic [CW-1:0]     burst_x;
   logic [CW-1:0]     take;
   logic [ADDR_W-1:0] step_bytes;
   logic [ADDR_W-1:0] next_line;
   logic              fin;
   logic              line_last;

   assign page_words = act_page[PAGE_W-1:2];
   assign burst_x    = CW'(burst);
   assign take       = (left < burst_x) ? left : burst_x;
   assign step_bytes = ADDR_W'({take, 2'b00});
   assign next_line  = line_base + act_page + act_skip;
   assign line_last  = (left == take);
   assign fin        = (line_base >= act_end) || (page_words == '0);

   assign req_valid = (st == WK_RUN) && !fin;
   assign req_addr  = cur;
   assign req_len   = take[LEN_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st         <= WK_IDLE;
         line_base  <= '0;
         cur        <= '0;
         left       <= '0;
         frame_done <= 1'b0;
      end else begin
         frame_done <= 1'b0;
         if (frame_start) begin
            st <= WK_LOAD;
         end else begin
            unique case (st)
               WK_LOAD: begin
                  line_base <= act_start;
                  cur       <= act_start;
                  left      <= page_words;
                  st        <= WK_RUN;
               end
               WK_RUN: begin
                  if (fin) begin
                     st         <= WK_IDLE;
                     frame_done <= 1'b1;
                  end else if (req_ready) begin
                     if (line_last) begin
                        line_base <= next_line;
                        cur       <= next_line;
                        left      <= page_words;
                     end else begin
                        cur  <= cur + step_bytes;
                        left <= left - take;
                     end
                  end
               end
               default: st <= WK_IDLE;
            endcase
         end
      end
   end

endmodule

// File: rtl/win_fetch_addr_gen.sv
module win_fetch_addr_gen
   import fwag_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned PAGE_W     = 16,
   parameter int unsigned WIDTH_W    = 12,
   parameter int unsigned NARROW_PIX = 128
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [1:0]         wr_sel,
   input  logic [ADDR_W-1:0]  wr_data,
   input  logic [1:0]         fmt,
   input  logic [WIDTH_W-1:0] buf_width,
   input  logic               frame_start,
   input  logic               req_ready,
   output logic               req_valid,
   output logic [ADDR_W-1:0]  req_addr,
   output logic [4:0]         req_len,
   output logic               frame_done,
   output logic               shadow_match
);

   if (PAGE_W < 8) begin : g_bad_page
      $error("PAGE_W must be at least 8");
   end
   if (ADDR_W < PAGE_W) begin : g_bad_addr
      $error("ADDR_W must not be smaller than PAGE_W");
   end
   if (LEN_W != 5) begin : g_bad_len
      $error("request length field must be 5 bits");
   end

   logic [ADDR_W-1:0] sh_start;
   logic [ADDR_W-1:0] act_start;
   logic [ADDR_W-1:0] act_end;
   logic [ADDR_W-1:0] act_page;
   logic [ADDR_W-1:0] act_skip;
   logic [LEN_W-1:0]  burst;

   fwag_shadow_regs #(.ADDR_W(ADDR_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_sel    (wr_sel),
      .wr_data   (wr_data),
      .load      (frame_start),
      .sh_start  (sh_start),
      .act_start (act_start),
      .act_end   (act_end),
      .act_page  (act_page),
      .act_skip  (act_skip)
   );

   fwag_burst_sel #(.WIDTH_W(WIDTH_W), .NARROW_PIX(NARROW_PIX)) u_burst (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (frame_start),
      .fmt       (fmt),
      .buf_width (buf_width),
      .burst     (burst)
   );

   fwag_walker #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_walk (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_start (frame_start),
      .act_start   (act_start),
      .act_end     (act_end),
      .act_page    (act_page),
      .act_skip    (act_skip),
      .burst       (burst),
      .req_ready   (req_ready),
      .req_valid   (req_valid),
      .req_addr    (req_addr),
      .req_len     (req_len),
      .frame_done  (frame_done)
   );

   assign shadow_match = (act_start == sh_start);

endmodule

// File: rtl/fwag_checker.sv
module fwag_checker #(
   parameter int unsigned ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frame_start,
   input logic              req_ready,
   input logic              req_valid,
   input logic [ADDR_W-1:0] req_addr,
   input logic [4:0]        req_len,
   input logic              frame_done
);

   // R7: a stalled request keeps its address and length
   a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready && !frame_start)
      |=> (req_valid && $stable(req_addr) && $stable(req_len)));

   // R4: request length stays within one to sixteen words
   a_r4_len_range: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (req_len != 5'd0 && req_len <= 5'd16));

   // R6: completion lasts one cycle
   a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> !frame_done);

   // R6: no request alongside completion
   a_r6_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> !req_valid);

   // R1: restart leaves a request-free cycle
   a_r1_restart_gap: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> !req_valid);

endmodule

bind win_fetch_addr_gen fwag_checker #(.ADDR_W(ADDR_W)) u_fwag_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .frame_start (frame_start),
   .req_ready   (req_ready),
   .req_valid   (req_valid),
   .req_addr    (req_addr),
   .req_len     (req_len),
   .frame_done  (frame_done)
);

// File: tb/win_fetch_addr_gen_test.sv
module win_fetch_addr_gen_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = 2'd0;
   logic [31:0] wr_data = '0;
   logic [1:0]  fmt = 2'd0;
   logic [11:0] buf_width = '0;
   logic        frame_start = 1'b0;
   logic        req_ready = 1'b0;
   logic        req_valid;
   logic [31:0] req_addr;
   logic [4:0]  req_len;
   logic        frame_done;
   logic        shadow_match;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   always #4 clk = ~clk;

   win_fetch_addr_gen uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .fmt(fmt), .buf_width(buf_width), .frame_start(frame_start),
      .req_ready(req_ready), .req_valid(req_valid), .req_addr(req_addr),
      .req_len(req_len), .frame_done(frame_done), .shadow_match(shadow_match)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         chk(1'b0, "R6", "watchdog expired", cyc, 150000);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   task automatic wr(input int sel, input longint d);
      wr_en   = 1'b1;
      wr_sel  = sel[1:0];
      wr_data = d[31:0];
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic run_frame(input longint st, input longint en, input longint pg,
                            input longint sk, input int fmt_i, input int wid,
                            input int rmode, input bit midw);
      longint lb, a, left, l, h_a, h_l;
      int     exp_b, nhs;
      bit     model_done, got_done, hold_pend, wrote, sm_checked, rdy;
      string  tag;
      wr(0, st); wr(1, en); wr(2, pg); wr(3, sk);
      fmt         = fmt_i[1:0];
      buf_width   = wid[11:0];
      frame_start = 1'b1;
      @(negedge clk);
      frame_start = 1'b0;
      exp_b      = (wid < 128) ? 4 : ((fmt_i == 0) ? 8 : 16);
      lb         = st;
      a          = st;
      left       = pg / 4;
      model_done = (lb >= en) || (left == 0);
      got_done   = 1'b0;
      hold_pend  = 1'b0;
      wrote      = 1'b0;
      sm_checked = 1'b0;
      nhs        = 0;
      for (int k = 0; k < 3000 && !got_done; k++) begin
         if (wr_en) wr_en = 1'b0;
         if (wrote && !sm_checked && k > 0) begin
            // R9 and R8: new shadow start differs from the active one
            chk(!shadow_match, "R9", "match after mid-frame write", shadow_match, 0);
            sm_checked = 1'b1;
         end
         rdy = (rmode == 0) ? 1'b1 : ((rmode == 1) ? k[0] : (k % 3 == 2));
         req_ready = rdy;
         if (hold_pend) begin
            chk(req_valid && req_addr == h_a[31:0] && req_len == h_l[4:0],
                "R7", "stalled request changed", req_addr, h_a);
            hold_pend = 1'b0;
         end
         if (frame_done) begin
            got_done = 1'b1;
            chk(model_done, "R6", "done before rectangle finished", a, lb);
         end else if (req_valid) begin
            if (rdy) begin
               if (model_done) begin
                  chk(1'b0, "R6", "request after end address", req_addr, en);
               end else begin
                  l = (left < exp_b) ? left : exp_b;
                  if (a != lb)       tag = "R4";
                  else if (lb == st) tag = "R1";
                  else               tag = "R5";
                  chk(req_addr == a[31:0], tag, "request address", req_addr, a);
                  chk(req_len == l[4:0], "R4", "request length", req_len, l);
                  if (a == lb && left >= 16)
                     chk(req_len == 5'(exp_b), (wid < 128) ? "R3" : "R2",
                         "burst length", req_len, exp_b);
                  nhs++;
                  if (l == left) begin
                     lb = lb + pg + sk;
                     a = lb;
                     left = pg / 4;
                     model_done = (lb >= en);
                  end else begin
                     a = a + 4 * l;
                     left = left - l;
                  end
                  if (midw && !wrote) begin
                     wr_en   = 1'b1;
                     wr_sel  = 2'd0;
                     wr_data = st[31:0] + 32'h1000;
                     wrote   = 1'b1;
                  end
               end
            end else begin
               hold_pend = 1'b1;
               h_a = req_addr;
               h_l = req_len;
            end
         end
         @(negedge clk);
      end
      if (!got_done) chk(1'b0, "R6", "frame never finished", nhs, 0);
      for (int q = 0; q < 3; q++) begin
         chk(!req_valid && !frame_done, "R6", "activity after done",
             {req_valid, frame_done}, 0);
         @(negedge clk);
      end
      if (!wrote) chk(shadow_match, "R9", "match after frame load", shadow_match, 1);
   endtask

   int pages[4]  = '{4, 36, 64, 100};
   int widths[3] = '{127, 128, 200};

   initial begin
      int n;
      repeat (3) @(negedge clk);
      // R10: reset state
      chk(!req_valid, "R10", "req_valid in reset", req_valid, 0);
      chk(!frame_done, "R10", "frame_done in reset", frame_done, 0);
      chk(shadow_match, "R10", "shadow_match in reset", shadow_match, 1);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!req_valid && shadow_match, "R10", "state after reset release",
          {req_valid, shadow_match}, 1);

      // R9: start write without frame start lowers the match
      wr(0, 32'h40);
      chk(!shadow_match, "R9", "match after start write", shadow_match, 0);

      // R6: empty rectangle and zero page width
      run_frame(32'h500, 32'h500, 32, 0, 1, 200, 0, 1'b0);
      run_frame(32'h600, 32'h700, 0, 16, 2, 200, 0, 1'b0);
      run_frame(32'h600, 32'h700, 3, 16, 0, 200, 1, 1'b0);

      n = 0;
      for (int f = 0; f < 4; f++)
         for (int wi = 0; wi < 3; wi++)
            for (int pi = 0; pi < 4; pi++)
               for (int si = 0; si < 2; si++)
                  for (int h = 1; h <= 3; h++) begin
                     longint st, pg, sk;
                     st = 64'h2000 + n * 64'h40;
                     pg = pages[pi];
                     sk = si * 8;
                     run_frame(st, st + (pg + sk) * h, pg, sk, f, widths[wi],
                               n % 3, (n % 5) == 0);
                     n++;
                  end

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule